// File: doc/BRIEF.md
# Nine-Valued Logic Latch Register Bank

This block is a bank of level-sensitive storage bits for logic that carries nine levels instead of two. Every data bit, and each of the three shared controls, is a 4-bit code for one of these levels: uninitialised, unknown, strong low, strong high, high impedance, weak unknown, weak low, weak high and don't-care. There is one open-high enable and two clear/preset controls that act when low. All bits share the same enable and the same clear and preset.

The clear and preset controls take priority over the enable. When neither of them is asserted, the bank is transparent while the enable is high and holds its contents while the enable is low. The output is the current value after a strength remap. A parameter selects the remap from ten fixed triples, and each triple names the driven level for the unknown, low and high groups. The remap touches only the output and never the stored contents. A clocked holding register keeps the latched value from one cycle to the next. Its asynchronous active-low system reset puts every bit into the uninitialised level. Controls and data reach the output combinationally, so a change is visible in the same cycle. Propagation delays are taken as zero.

Top module: `nvl_latch_bank`

## Requirements
- R1: Level codes are U=0, X=1, 0=2, 1=3, Z=4, W=5, L=6, H=7, don't-care=8. With clear and preset both at 1 or H and the enable at 1 or H, each bit's current value equals its data input in the same cycle.
- R2: With clear and preset both inactive and the enable at 0 or L, each bit keeps the value it had at the end of the previous cycle, and the data input has no effect on it.
- R3: With clear and preset both inactive and the enable at U, X, Z, W, don't-care or an out-of-range code, a bit whose data input matches its held value keeps that value. A bit whose data input differs becomes X.
- R4: Clear at 0 or L with preset at 1 or H forces every bit to 0, whatever the enable and data. After the clear is released with the enable low, the bits hold 0.
- R5: Preset at 0 or L with clear at 1 or H forces every bit to 1. After the preset is released with the enable low, the bits hold 1.
- R6: Clear and preset both at 0 or L force every bit to X.
- R7: When either control is at X, Z, W, don't-care or an out-of-range code and neither control is U, every bit is forced to X.
- R8: U on clear or on preset forces every bit to U. This takes priority over every other control combination.
- R9: While the system reset is low, every stored bit is U.
- R10: The output remap, with the triple (unknown, low, high) chosen from X01 (default), X0H, XL1, X0Z, XZ1, WLH, WLZ, WZH, W0H and WL1, sends U to U, sends X, Z, W and don't-care to the unknown letter, sends 0 and L to the low letter, and sends 1 and H to the high letter.
- R11: Data or control codes 9 to 15 are treated as X. Data with such a code is stored as X.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the holding register |
| rst_n | input | 1 | Asynchronous active-low system reset; stored bits become U |
| lvl_d | input | WIDTH*4 | Per-bit data levels, bit i at [4i+3:4i] |
| ctl_en | input | 4 | Shared enable level, open when high |
| ctl_clr_n | input | 4 | Shared clear level, active when low |
| ctl_pre_n | input | 4 | Shared preset level, active when low |
| q_lvl | output | WIDTH*4 | Remapped current level of each bit |

## Verification
A wrong stored level shows up at the output in the same cycle as the first hold or fuzzy-enable step that reads it. If the holding register missed a load, a following enable-low step would show the older value. The fuzzy-enable case compares data against the held value bit by bit, so it reveals a wrong held level even on bits whose data did not change. A second instance with a non-default remap shows, within the same step, whether U, the low group or the unknown group has been sent to the wrong letter.

// File: rtl/nvl_pkg.sv
package nvl_pkg;

  localparam int LVL_W = 4;

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LV_U  = 4'd0;
  localparam lvl_t LV_X  = 4'd1;
  localparam lvl_t LV_0  = 4'd2;
  localparam lvl_t LV_1  = 4'd3;
  localparam lvl_t LV_Z  = 4'd4;
  localparam lvl_t LV_W  = 4'd5;
  localparam lvl_t LV_L  = 4'd6;
  localparam lvl_t LV_H  = 4'd7;
  localparam lvl_t LV_DC = 4'd8;

  typedef enum logic [1:0] {GRP_UNDEF, GRP_UNK, GRP_LOW, GRP_HIGH} grp_e;

  typedef enum logic [2:0] {
    MD_HOLD, MD_PASS, MD_FUZZY, MD_FORCE_U, MD_FORCE_0, MD_FORCE_1, MD_FORCE_X
  } mode_e;

  typedef enum logic [3:0] {
    SM_X01, SM_X0H, SM_XL1, SM_X0Z, SM_XZ1,
    SM_WLH, SM_WLZ, SM_WZH, SM_W0H, SM_WL1
  } strength_e;

  typedef struct packed {
    lvl_t unk;
    lvl_t low;
    lvl_t high;
  } sm_set_t;

  // out-of-range codes collapse to unknown
  function automatic lvl_t lvl_norm(input lvl_t l);
    return (l > LV_DC) ? LV_X : l;
  endfunction

  function automatic grp_e lvl_grp(input lvl_t l);
    grp_e g;
    case (l)
      LV_U:       g = GRP_UNDEF;
      LV_0, LV_L: g = GRP_LOW;
      LV_1, LV_H: g = GRP_HIGH;
      default:    g = GRP_UNK;
    endcase
    return g;
  endfunction

  function automatic sm_set_t sm_letters(input strength_e s);
    sm_set_t r;
    case (s)
      SM_X0H:  r = '{unk: LV_X, low: LV_0, high: LV_H};
      SM_XL1:  r = '{unk: LV_X, low: LV_L, high: LV_1};
      SM_X0Z:  r = '{unk: LV_X, low: LV_0, high: LV_Z};
      SM_XZ1:  r = '{unk: LV_X, low: LV_Z, high: LV_1};
      SM_WLH:  r = '{unk: LV_W, low: LV_L, high: LV_H};
      SM_WLZ:  r = '{unk: LV_W, low: LV_L, high: LV_Z};
      SM_WZH:  r = '{unk: LV_W, low: LV_Z, high: LV_H};
      SM_W0H:  r = '{unk: LV_W, low: LV_0, high: LV_H};
      SM_WL1:  r = '{unk: LV_W, low: LV_L, high: LV_1};
      default: r = '{unk: LV_X, low: LV_0, high: LV_1};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nvl_mode_decode.sv
module nvl_mode_decode
  import nvl_pkg::*;
(
  input  lvl_t  ctl_en,
  input  lvl_t  ctl_clr_n,
  input  lvl_t  ctl_pre_n,
  output mode_e mode
);

  grp_e clr_g;
  grp_e pre_g;
  grp_e en_g;

  assign clr_g = lvl_grp(ctl_clr_n);
  assign pre_g = lvl_grp(ctl_pre_n);
  assign en_g  = lvl_grp(ctl_en);

  always_comb begin
    if (clr_g == GRP_UNDEF || pre_g == GRP_UNDEF) begin
      mode = MD_FORCE_U;
    end else if (clr_g == GRP_LOW && pre_g == GRP_LOW) begin
      mode = MD_FORCE_X;
    end else if (clr_g == GRP_UNK || pre_g == GRP_UNK) begin
      mode = MD_FORCE_X;
    end else if (clr_g == GRP_LOW) begin
      mode = MD_FORCE_0;
    end else if (pre_g == GRP_LOW) begin
      mode = MD_FORCE_1;
    end else begin
      case (en_g)
        GRP_HIGH: mode = MD_PASS;
        GRP_LOW:  mode = MD_HOLD;
        default:  mode = MD_FUZZY;
      endcase
    end
  end

endmodule

// File: rtl/nvl_bit_cell.sv
module nvl_bit_cell
  import nvl_pkg::*;
(
  input  mode_e mode,
  input  lvl_t  d_lvl,
  input  lvl_t  held,
  output lvl_t  nxt
);

  lvl_t d_n;
  assign d_n = lvl_norm(d_lvl);

  always_comb begin
    case (mode)
      MD_PASS:    nxt = d_n;
      MD_HOLD:    nxt = held;
      MD_FUZZY:   nxt = (d_n == held) ? held : LV_X;
      MD_FORCE_U: nxt = LV_U;
      MD_FORCE_0: nxt = LV_0;
      MD_FORCE_1: nxt = LV_1;
      default:    nxt = LV_X;
    endcase
  end

endmodule

// File: rtl/nvl_strength_map.sv
module nvl_strength_map
  import nvl_pkg::*;
#(
  parameter strength_e STRENGTH = SM_X01
) (
  input  lvl_t in_lvl,
  output lvl_t out_lvl
);

  localparam sm_set_t LET = sm_letters(STRENGTH);

  always_comb begin
    case (lvl_grp(in_lvl))
      GRP_UNDEF: out_lvl = LV_U;
      GRP_LOW:   out_lvl = LET.low;
      GRP_HIGH:  out_lvl = LET.high;
      default:   out_lvl = LET.unk;
    endcase
  end

endmodule

// File: rtl/nvl_latch_bank.sv
module nvl_latch_bank
  import nvl_pkg::*;
#(
  parameter int        WIDTH    = 8,
  parameter strength_e STRENGTH = SM_X01
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WIDTH*LVL_W-1:0] lvl_d,
  input  logic [LVL_W-1:0]       ctl_en,
  input  logic [LVL_W-1:0]       ctl_clr_n,
  input  logic [LVL_W-1:0]       ctl_pre_n,
  output logic [WIDTH*LVL_W-1:0] q_lvl
);

  localparam int DW = WIDTH * LVL_W;

  mode_e                  mode;
  logic                   load;
  logic [WIDTH-1:0][LVL_W-1:0] hold_q;
  logic [WIDTH-1:0][LVL_W-1:0] cur;

  nvl_mode_decode u_mode (
    .ctl_en    (ctl_en),
    .ctl_clr_n (ctl_clr_n),
    .ctl_pre_n (ctl_pre_n),
    .mode      (mode)
  );

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      nvl_bit_cell u_cell (
        .mode  (mode),
        .d_lvl (lvl_d[gi*LVL_W +: LVL_W]),
        .held  (hold_q[gi]),
        .nxt   (cur[gi])
      );
      nvl_strength_map #(.STRENGTH(STRENGTH)) u_map (
        .in_lvl  (cur[gi]),
        .out_lvl (q_lvl[gi*LVL_W +: LVL_W])
      );
    end
  endgenerate

  // holding register only reloads when the value can change
  assign load = (mode != MD_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0; // every bit U
    end else if (load) begin
      hold_q <= cur;
    end
  end

  logic [DW-1:0] unused_w;
  assign unused_w = '0;

endmodule

module nvl_latch_bank_chk
  import nvl_pkg::*;
#(
  parameter int        WIDTH    = 8,
  parameter strength_e STRENGTH = SM_X01
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [WIDTH*LVL_W-1:0] lvl_d,
  input logic [LVL_W-1:0]       ctl_en,
  input logic [LVL_W-1:0]       ctl_clr_n,
  input logic [LVL_W-1:0]       ctl_pre_n,
  input logic [WIDTH*LVL_W-1:0] q_lvl,
  input logic [WIDTH*LVL_W-1:0] hold_q
);

  localparam sm_set_t LET = sm_letters(STRENGTH);

  logic clr_act, pre_act, clr_idle, pre_idle, any_u;
  logic en_hi, en_lo;
  logic all_low, all_high, all_unk, all_u, store_u;

  always_comb begin
    clr_act  = (ctl_clr_n == LV_0) || (ctl_clr_n == LV_L);
    pre_act  = (ctl_pre_n == LV_0) || (ctl_pre_n == LV_L);
    clr_idle = (ctl_clr_n == LV_1) || (ctl_clr_n == LV_H);
    pre_idle = (ctl_pre_n == LV_1) || (ctl_pre_n == LV_H);
    any_u    = (ctl_clr_n == LV_U) || (ctl_pre_n == LV_U);
    en_hi    = (ctl_en == LV_1) || (ctl_en == LV_H);
    en_lo    = (ctl_en == LV_0) || (ctl_en == LV_L);
    all_low  = 1'b1;
    all_high = 1'b1;
    all_unk  = 1'b1;
    all_u    = 1'b1;
    store_u  = 1'b1;
    for (int i = 0; i < WIDTH; i++) begin
      if (q_lvl[i*LVL_W +: LVL_W] != LET.low)  all_low  = 1'b0;
      if (q_lvl[i*LVL_W +: LVL_W] != LET.high) all_high = 1'b0;
      if (q_lvl[i*LVL_W +: LVL_W] != LET.unk)  all_unk  = 1'b0;
      if (q_lvl[i*LVL_W +: LVL_W] != LV_U)     all_u    = 1'b0;
      if (hold_q[i*LVL_W +: LVL_W] != LV_U)    store_u  = 1'b0;
    end
  end

  // R1
  pass_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hi && clr_idle && pre_idle && $past(en_hi && clr_idle && pre_idle) && $stable(lvl_d))
      |-> $stable(q_lvl));

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_lo && clr_idle && pre_idle && $past(rst_n)) |-> (q_lvl == $past(q_lvl)));

  // R4
  clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && pre_idle) |-> all_low);

  // R5
  preset_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_act && clr_idle) |-> all_high);

  // R6
  both_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && pre_act) |-> all_unk);

  // R8
  undef_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_u |-> all_u);

  // R9
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_undef_chk: assert (store_u);
    end
  end

endmodule

bind nvl_latch_bank nvl_latch_bank_chk #(.WIDTH(WIDTH), .STRENGTH(STRENGTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lvl_d     (lvl_d),
  .ctl_en    (ctl_en),
  .ctl_clr_n (ctl_clr_n),
  .ctl_pre_n (ctl_pre_n),
  .q_lvl     (q_lvl),
  .hold_q    (hold_q)
);

// File: tb/nvl_latch_bank_tb.sv
module nvl_latch_bank_tb;
  import nvl_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 4;
  localparam int DW         = WIDTH * LVL_W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] lvl_d;
  logic [3:0]    ctl_en, ctl_clr_n, ctl_pre_n;
  logic [DW-1:0] q_a, q_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [DW-1:0] exp_a;
    logic [DW-1:0] exp_b;
    string         tag;
  } item_t;

  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvl_latch_bank #(.WIDTH(WIDTH), .STRENGTH(SM_X01)) u_dut (
    .clk(clk), .rst_n(rst_n), .lvl_d(lvl_d), .ctl_en(ctl_en),
    .ctl_clr_n(ctl_clr_n), .ctl_pre_n(ctl_pre_n), .q_lvl(q_a)
  );

  nvl_latch_bank #(.WIDTH(WIDTH), .STRENGTH(SM_WZH)) u_dut_wzh (
    .clk(clk), .rst_n(rst_n), .lvl_d(lvl_d), .ctl_en(ctl_en),
    .ctl_clr_n(ctl_clr_n), .ctl_pre_n(ctl_pre_n), .q_lvl(q_b)
  );

  function automatic logic [DW-1:0] v4(input lvl_t b3, input lvl_t b2,
                                        input lvl_t b1, input lvl_t b0);
    return {b3, b2, b1, b0};
  endfunction

  function automatic logic [DW-1:0] all4(input lvl_t l);
    return {l, l, l, l};
  endfunction

  task automatic step(input logic [DW-1:0] d, input lvl_t en, input lvl_t clr,
                      input lvl_t pre, input logic [DW-1:0] ea,
                      input logic [DW-1:0] eb, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    lvl_d     = d;
    ctl_en    = en;
    ctl_clr_n = clr;
    ctl_pre_n = pre;
    it.exp_a  = ea;
    it.exp_b  = eb;
    it.tag    = tag;
    sb.push_back(it);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor: compare both instances at mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (q_a !== it.exp_a || q_b !== it.exp_b) begin
          errors++;
          $display("FAIL %s: actual x01=%h wzh=%h expected x01=%h wzh=%h",
                   it.tag, q_a, q_b, it.exp_a, it.exp_b);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    lvl_d     = all4(LV_1);
    ctl_en    = LV_0;
    ctl_clr_n = LV_1;
    ctl_pre_n = LV_1;

    // R9 reset state
    step(all4(LV_1), LV_0, LV_1, LV_1, all4(LV_U), all4(LV_U), "R9 reset");
    @(posedge clk); #1 rst_n = 1'b1;
    step(all4(LV_1), LV_0, LV_1, LV_1, all4(LV_U), all4(LV_U), "R9 after release");

    // R1 / R10 transparent with remap
    step(v4(LV_1, LV_0, LV_H, LV_L), LV_1, LV_1, LV_1,
         v4(LV_1, LV_0, LV_1, LV_0), v4(LV_H, LV_Z, LV_H, LV_Z), "R1 R10 pass");
    // R2 hold, data changed
    step(all4(LV_0), LV_0, LV_1, LV_1,
         v4(LV_1, LV_0, LV_1, LV_0), v4(LV_H, LV_Z, LV_H, LV_Z), "R2 hold en0");
    step(all4(LV_1), LV_L, LV_H, LV_H,
         v4(LV_1, LV_0, LV_1, LV_0), v4(LV_H, LV_Z, LV_H, LV_Z), "R2 hold enL");
    // R10 unknown group
    step(v4(LV_X, LV_W, LV_Z, LV_DC), LV_H, LV_1, LV_1,
         all4(LV_X), all4(LV_W), "R10 unknown group");
    // R11 out-of-range data, U kept
    step(v4(LV_U, 4'd15, LV_1, LV_0), LV_1, LV_1, LV_1,
         v4(LV_U, LV_X, LV_1, LV_0), v4(LV_U, LV_W, LV_H, LV_Z), "R11 R10 U and code 15");
    // R3 fuzzy enable
    step(v4(LV_U, LV_0, LV_1, LV_1), LV_X, LV_1, LV_1,
         v4(LV_U, LV_X, LV_1, LV_X), v4(LV_U, LV_W, LV_H, LV_W), "R3 enable X");
    step(v4(LV_U, LV_X, LV_1, LV_X), 4'd13, LV_1, LV_1,
         v4(LV_U, LV_X, LV_1, LV_X), v4(LV_U, LV_W, LV_H, LV_W), "R3 R11 enable code 13");
    step(v4(LV_1, LV_1, LV_0, LV_0), LV_1, LV_1, LV_1,
         v4(LV_1, LV_1, LV_0, LV_0), v4(LV_H, LV_H, LV_Z, LV_Z), "R1 pass");
    // R4 clear
    step(all4(LV_1), LV_1, LV_0, LV_1, all4(LV_0), all4(LV_Z), "R4 clear");
    step(all4(LV_1), LV_0, LV_1, LV_1, all4(LV_0), all4(LV_Z), "R4 held after clear");
    // R5 preset
    step(all4(LV_0), LV_0, LV_H, LV_L, all4(LV_1), all4(LV_H), "R5 preset");
    step(all4(LV_0), LV_0, LV_1, LV_1, all4(LV_1), all4(LV_H), "R5 held after preset");
    // R6 both
    step(all4(LV_1), LV_1, LV_0, LV_0, all4(LV_X), all4(LV_W), "R6 both active");
    step(all4(LV_1), LV_0, LV_1, LV_1, all4(LV_X), all4(LV_W), "R6 held X");
    // R7 unknown controls
    step(all4(LV_0), LV_1, LV_Z, LV_1, all4(LV_X), all4(LV_W), "R7 clear Z");
    step(all4(LV_0), LV_0, LV_1, LV_W, all4(LV_X), all4(LV_W), "R7 preset W");
    step(all4(LV_0), LV_0, LV_0, 4'd12, all4(LV_X), all4(LV_W), "R7 R11 preset code 12");
    // R8 U priority
    step(all4(LV_1), LV_1, LV_U, LV_0, all4(LV_U), all4(LV_U), "R8 clear U");
    step(all4(LV_1), LV_0, LV_1, LV_1, all4(LV_U), all4(LV_U), "R8 held U");
    step(all4(LV_1), LV_1, LV_1, LV_U, all4(LV_U), all4(LV_U), "R8 preset U");
    step(v4(LV_H, LV_L, LV_Z, LV_DC), LV_H, LV_1, LV_1,
         v4(LV_1, LV_0, LV_X, LV_X), v4(LV_H, LV_Z, LV_W, LV_W), "R1 R10 mixed");

    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule